// File: doc/BRIEF.md
# Windowed Indirect Register Access Bridge

This bridge turns one flat management-register request into two back-to-back transfers on a narrow memory-mapped register bus. The bridge first builds a full management address. With the clause-45 flag set, the request's register field is used as that address. Otherwise the configured device number fills the upper bits and the low 16 bits of the register field fill the rest. The bridge then splits the address in two with a window mask. The unmasked upper part is the window index, which is written as a 32-bit value to a window-select register. The masked lower part, added to a window base, gives a halfword offset. The bridge then performs a 16-bit read or write at twice that offset.

The request side is a valid/ready port. `req_ready` is high only while the bridge is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the data transfer completes, so a waiting requester is back-pressured for the whole two-phase access. On the bus side, `bus_valid` is held with stable fields until the target raises `bus_ready`. Completion is reported by a one-cycle `rsp_done` pulse, with `rsp_rdata` carrying read data. A request made while the bridge is in first-generation mode (`cfg_gen2` low) is refused: it gets an error response and causes no bus traffic.

Top module: `win_reg_bridge`

## Requirements
- R1: With `req_c45` = 1, the full address is `req_reg` as supplied.
- R2: With `req_c45` = 0, the full address is `{cfg_dev, req_reg[15:0]}`; the upper bits of `req_reg` are ignored.
- R3: The first bus transfer after acceptance is a write (`bus_we` = 1) with `bus_wide` = 1 to `cfg_sel_addr`. Its data is the full address AND NOT `cfg_win_mask`, zero-extended to 32 bits.
- R4: The second transfer has `bus_wide` = 0 and byte address `{(cfg_win_base + (full & cfg_win_mask)) mod 2^(BUS_AW-1), 1'b0}`.
- R5: The data transfer is raised on the cycle after the select transfer completes. `req_ready` and `bus_valid` are never high together, and exactly one of them is high at any time out of reset.
- R6: The cycle after a read data transfer completes, `rsp_done` = 1, `rsp_err` = 0, and `rsp_rdata` equals the `bus_rdata` seen at completion.
- R7: On a write request, the data transfer has `bus_we` = 1 and `bus_wdata` = `{16'h0, req_wdata}`. The done pulse that follows has `rsp_err` = 0 and `rsp_rdata` = 0.
- R8: A request accepted while `cfg_gen2` = 0 gives `rsp_done` = 1, `rsp_err` = 1 and `rsp_rdata` = 0 on the next cycle. `bus_valid` stays low and `req_ready` stays high.
- R9: Configuration inputs and request fields are sampled at acceptance. Changing them later has no effect on the transfers already under way.
- R10: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_wdata`, `bus_we` and `bus_wide` hold their values.
- R11: Out of reset, `req_ready` = 1, `bus_valid` = 0 and `rsp_done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gen2 | input | 1 | 1: second-generation scheme active; 0: refuse requests |
| cfg_dev | input | DEV_W | Device number used for clause-22 addresses |
| cfg_win_base | input | BUS_AW-1 | Halfword base of the data window |
| cfg_win_mask | input | DEV_W+16 | Bits of the full address that lie inside the window |
| cfg_sel_addr | input | BUS_AW | Byte address of the window-select register |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_c45 | input | 1 | Clause-45 addressing flag |
| req_we | input | 1 | 1: write, 0: read |
| req_reg | input | DEV_W+16 | Register number |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Refused request, valid with rsp_done |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| bus_valid | output | 1 | Bus transfer request |
| bus_ready | input | 1 | Bus transfer completes this cycle |
| bus_we | output | 1 | Bus write |
| bus_wide | output | 1 | 1: 32-bit select transfer, 0: 16-bit data transfer |
| bus_addr | output | BUS_AW | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 16 | Bus read data, sampled with bus_ready |

## Verification
The bench sweeps several window masks and bases, both addressing modes, reads and writes, and zero to two stall cycles per transfer. One base is chosen so that the offset sum wraps. A bridge that forgot the halfword-to-byte shift, or that dropped the wrap, would land the data transfer at the wrong address. Clause-22 requests carry junk in the upper register bits, so a design that let those bits through would show a wrong window index. Mid-transaction, the bench scrambles every configuration input. A design that read configuration live, instead of at acceptance, would drift its addresses. A refused request would show up as stray bus traffic or a missing error pulse.

// File: rtl/wrb_pkg.sv
`timescale 1ns/1ps
package wrb_pkg;
  localparam int HALF_W = 16;
  localparam int SEL_W  = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_DATA = 2'd2
  } wrb_state_e;
endpackage

// File: rtl/wrb_addr_calc.sv
`timescale 1ns/1ps
module wrb_addr_calc
  import wrb_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int OFF_W  = 19,
  localparam int ADDR_W = DEV_W + HALF_W
) (
  input  logic [DEV_W-1:0]  dev,
  input  logic [ADDR_W-1:0] reg_num,
  input  logic              c45,
  input  logic [ADDR_W-1:0] win_mask,
  input  logic [OFF_W-1:0]  win_base,
  output logic [SEL_W-1:0]  win_index,
  output logic [OFF_W:0]    byte_off
);
  logic [ADDR_W-1:0] full_addr;
  logic [ADDR_W-1:0] in_window;
  logic [OFF_W-1:0]  half_off;

  always_comb begin
    if (c45) full_addr = reg_num;
    else     full_addr = {dev, reg_num[HALF_W-1:0]};
  end

  assign in_window = full_addr & win_mask;
  assign win_index = SEL_W'(full_addr & ~win_mask);
  assign half_off  = win_base + OFF_W'(in_window);
  // halfword offset to byte address
  assign byte_off  = {half_off, 1'b0};
endmodule

// File: rtl/wrb_seq.sv
`timescale 1ns/1ps
module wrb_seq
  import wrb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       gen2,
  input  logic       bus_ready,
  output wrb_state_e state,
  output logic       accept,
  output logic       data_fire,
  output logic       done,
  output logic       err
);
  wrb_state_e nxt;

  assign accept    = req_valid && (state == ST_IDLE);
  assign data_fire = (state == ST_DATA) && bus_ready;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (accept && gen2) nxt = ST_SEL;
      ST_SEL:  if (bus_ready)      nxt = ST_DATA;
      ST_DATA: if (bus_ready)      nxt = ST_IDLE;
      default:                     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= nxt;
      done  <= data_fire || (accept && !gen2);
      err   <= accept && !gen2;
    end
  end
endmodule

// File: rtl/wrb_bus_mux.sv
`timescale 1ns/1ps
module wrb_bus_mux
  import wrb_pkg::*;
#(
  parameter int BUS_AW = 20
) (
  input  wrb_state_e        state,
  input  logic [BUS_AW-1:0] sel_addr,
  input  logic [SEL_W-1:0]  win_index,
  input  logic [BUS_AW-1:0] data_addr,
  input  logic              we,
  input  logic [HALF_W-1:0] wdata,
  output logic              bus_valid,
  output logic              bus_we,
  output logic              bus_wide,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [SEL_W-1:0]  bus_wdata
);
  always_comb begin
    bus_valid = (state != ST_IDLE);
    bus_wide  = (state == ST_SEL);
    if (state == ST_SEL) begin
      bus_we    = 1'b1;
      bus_addr  = sel_addr;
      bus_wdata = win_index;
    end else begin
      bus_we    = we;
      bus_addr  = data_addr;
      bus_wdata = {{(SEL_W-HALF_W){1'b0}}, wdata};
    end
  end
endmodule

// File: rtl/win_reg_bridge.sv
`timescale 1ns/1ps
module win_reg_bridge
  import wrb_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int BUS_AW = 20,
  localparam int ADDR_W = DEV_W + HALF_W,
  localparam int OFF_W  = BUS_AW - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_gen2,
  input  logic [DEV_W-1:0]  cfg_dev,
  input  logic [OFF_W-1:0]  cfg_win_base,
  input  logic [ADDR_W-1:0] cfg_win_mask,
  input  logic [BUS_AW-1:0] cfg_sel_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_c45,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [HALF_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [HALF_W-1:0] rsp_rdata,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic              bus_wide,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [SEL_W-1:0]  bus_wdata,
  input  logic [HALF_W-1:0] bus_rdata
);
  wrb_state_e        state;
  logic              accept;
  logic              data_fire;
  logic [SEL_W-1:0]  idx_calc;
  logic [BUS_AW-1:0] off_calc;

  logic [SEL_W-1:0]  idx_q;
  logic [BUS_AW-1:0] off_q;
  logic [BUS_AW-1:0] sel_q;
  logic              we_q;
  logic [HALF_W-1:0] wdata_q;

  wrb_addr_calc #(.DEV_W(DEV_W), .OFF_W(OFF_W)) u_calc (
    .dev       (cfg_dev),
    .reg_num   (req_reg),
    .c45       (req_c45),
    .win_mask  (cfg_win_mask),
    .win_base  (cfg_win_base),
    .win_index (idx_calc),
    .byte_off  (off_calc)
  );

  wrb_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .gen2      (cfg_gen2),
    .bus_ready (bus_ready),
    .state     (state),
    .accept    (accept),
    .data_fire (data_fire),
    .done      (rsp_done),
    .err       (rsp_err)
  );

  // capture everything the transaction needs at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      off_q   <= '0;
      sel_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      idx_q   <= idx_calc;
      off_q   <= off_calc;
      sel_q   <= cfg_sel_addr;
      we_q    <= req_we;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               rsp_rdata <= '0;
    else if (data_fire)       rsp_rdata <= we_q ? '0 : bus_rdata;
    else if (accept && !cfg_gen2) rsp_rdata <= '0;
  end

  assign req_ready = (state == ST_IDLE);

  wrb_bus_mux #(.BUS_AW(BUS_AW)) u_mux (
    .state     (state),
    .sel_addr  (sel_q),
    .win_index (idx_q),
    .data_addr (off_q),
    .we        (we_q),
    .wdata     (wdata_q),
    .bus_valid (bus_valid),
    .bus_we    (bus_we),
    .bus_wide  (bus_wide),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
  );
endmodule

// File: rtl/wrb_checker.sv
`timescale 1ns/1ps
module wrb_checker
  import wrb_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int BUS_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_gen2,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic [HALF_W-1:0] rsp_rdata,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_we,
  input logic              bus_wide,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [SEL_W-1:0]  bus_wdata,
  input logic [HALF_W-1:0] bus_rdata
);
  assert_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({req_ready, bus_valid}));

  assert_sel_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_valid) |-> bus_wide);

  assert_data_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_wide |=> bus_valid && !bus_wide);

  assert_sel_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_wide |-> bus_we);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
      $stable(bus_wdata) && $stable(bus_we) && $stable(bus_wide));

  assert_read_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_wide && !bus_we |=>
      rsp_done && !rsp_err && rsp_rdata == $past(bus_rdata));

  assert_write_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_wide && bus_we |=>
      rsp_done && !rsp_err && rsp_rdata == '0);

  assert_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !cfg_gen2 |=>
      rsp_done && rsp_err && !bus_valid && rsp_rdata == '0);
endmodule

bind win_reg_bridge wrb_checker #(.DEV_W(DEV_W), .BUS_AW(BUS_AW)) u_wrb_chk (.*);

// File: tb/tb_win_reg_bridge.sv
`timescale 1ns/1ps
module tb_win_reg_bridge;
  localparam int DEV_W  = 5;
  localparam int BUS_AW = 20;
  localparam int ADDR_W = DEV_W + 16;
  localparam int OFF_W  = BUS_AW - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_gen2 = 1'b1;
  logic [DEV_W-1:0]  cfg_dev = '0;
  logic [OFF_W-1:0]  cfg_win_base = '0;
  logic [ADDR_W-1:0] cfg_win_mask = '0;
  logic [BUS_AW-1:0] cfg_sel_addr = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_c45 = 1'b0;
  logic              req_we = 1'b0;
  logic [ADDR_W-1:0] req_reg = '0;
  logic [15:0]       req_wdata = '0;
  logic              rsp_done, rsp_err;
  logic [15:0]       rsp_rdata;
  logic              bus_valid;
  logic              bus_ready = 1'b0;
  logic              bus_we, bus_wide;
  logic [BUS_AW-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [15:0]       bus_rdata = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  win_reg_bridge #(.DEV_W(DEV_W), .BUS_AW(BUS_AW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic access(input logic [DEV_W-1:0] dev, input logic [ADDR_W-1:0] r,
                        input bit c45, input bit we, input logic [15:0] wd, input int stall);
    logic [ADDR_W-1:0] full;
    logic [31:0]       e_idx;
    logic [OFF_W-1:0]  e_half;
    logic [BUS_AW-1:0] e_off;
    logic [BUS_AW-1:0] e_sel;
    logic [15:0]       e_rd;
    logic [DEV_W-1:0]  s_dev;
    logic [OFF_W-1:0]  s_base;
    logic [ADDR_W-1:0] s_mask;
    logic [BUS_AW-1:0] s_sel;
    string             atag;
    full   = c45 ? r : {dev, r[15:0]};
    atag   = c45 ? "R1" : "R2";
    e_idx  = 32'(full & ~cfg_win_mask);
    e_half = cfg_win_base + OFF_W'(full & cfg_win_mask);
    e_off  = {e_half, 1'b0};
    e_sel  = cfg_sel_addr;
    e_rd   = e_off[15:0] ^ 16'hC35A;
    cfg_dev = dev;
    req_c45 = c45; req_we = we; req_reg = r; req_wdata = wd;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R5 idle ready", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    // select phase
    chk(bus_valid && bus_wide && bus_we, "R3 select transfer", {bus_valid, bus_wide, bus_we}, 3'b111);
    chk(bus_addr == e_sel, "R3 select address", bus_addr, e_sel);
    chk(bus_wdata == e_idx, {atag, " R3 window index"}, bus_wdata, e_idx);
    chk(req_ready == 1'b0, "R5 busy ready", req_ready, 0);
    // scramble configuration and request inputs after acceptance
    s_dev = cfg_dev; s_base = cfg_win_base; s_mask = cfg_win_mask; s_sel = cfg_sel_addr;
    cfg_dev = ~cfg_dev; cfg_win_base = ~cfg_win_base; cfg_win_mask = ~cfg_win_mask;
    cfg_sel_addr = ~cfg_sel_addr; req_reg = ~req_reg; req_wdata = ~req_wdata; req_we = ~req_we;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(bus_valid && bus_wide && bus_addr == e_sel && bus_wdata == e_idx, "R10 select hold",
          bus_addr, e_sel);
    end
    bus_ready = 1'b1;
    @(negedge clk);
    bus_ready = 1'b0;
    // data phase
    chk(bus_valid && !bus_wide, "R5 data follows select", {bus_valid, bus_wide}, 2'b10);
    chk(bus_addr == e_off, {atag, " R4 R9 data address"}, bus_addr, e_off);
    chk(bus_we == we, "R9 direction kept", bus_we, we);
    if (we) chk(bus_wdata == {16'h0, wd}, "R7 write data", bus_wdata, {16'h0, wd});
    chk(rsp_done == 1'b0, "R6 no early done", rsp_done, 0);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(bus_valid && !bus_wide && bus_addr == e_off && req_ready == 1'b0, "R10 data hold",
          bus_addr, e_off);
    end
    bus_rdata = e_rd;
    bus_ready = 1'b1;
    @(negedge clk);
    bus_ready = 1'b0;
    bus_rdata = 16'hFFFF;
    chk(rsp_done && !rsp_err, we ? "R7 done" : "R6 done", {rsp_done, rsp_err}, 2'b10);
    if (we) chk(rsp_rdata == 16'h0, "R7 rdata zero", rsp_rdata, 0);
    else    chk(rsp_rdata == e_rd, "R6 read data", rsp_rdata, e_rd);
    chk(req_ready && !bus_valid, "R5 back to idle", {req_ready, bus_valid}, 2'b10);
    cfg_dev = s_dev; cfg_win_base = s_base; cfg_win_mask = s_mask; cfg_sel_addr = s_sel;
    @(negedge clk);
    chk(rsp_done == 1'b0, "R6 done is a pulse", rsp_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !bus_valid && !rsp_done, "R11 reset state",
        {req_ready, bus_valid, rsp_done}, 3'b100);

    for (int m = 0; m < 3; m++) begin
      case (m)
        0: begin cfg_win_mask = 21'h000FF; cfg_win_base = 19'h10000; cfg_sel_addr = 20'h0F0F8; end
        1: begin cfg_win_mask = 21'h003FF; cfg_win_base = 19'h7FF80; cfg_sel_addr = 20'h00040; end
        default: begin cfg_win_mask = 21'h00FFF; cfg_win_base = 19'h02345; cfg_sel_addr = 20'hABCD0; end
      endcase
      for (int k = 0; k < 6; k++) begin
        for (int c = 0; c < 2; c++) begin
          for (int w = 0; w < 2; w++) begin
            access(DEV_W'(k * 7 + 3 + m),
                   ADDR_W'(k * 32'h2B5D3 + m * 32'h0C0DE + 32'h1A0F7),
                   c[0], w[0], 16'(k * 16'h1111 + m * 16'h0777 + 16'h8001), (k + m) % 3);
          end
        end
      end
    end

    // refused request in first-generation mode
    cfg_gen2 = 1'b0;
    req_valid = 1'b1; req_we = 1'b0; req_reg = 21'h12345;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_done && rsp_err, "R8 refuse pulse", {rsp_done, rsp_err}, 2'b11);
    chk(!bus_valid && req_ready, "R8 no bus access", {bus_valid, req_ready}, 2'b01);
    chk(rsp_rdata == 16'h0, "R8 rdata zero", rsp_rdata, 0);
    @(negedge clk);
    chk(!bus_valid && !rsp_done, "R8 stays quiet", {bus_valid, rsp_done}, 2'b00);
    cfg_gen2 = 1'b1;
    access(5'h1F, 21'h1FFFFF, 1'b0, 1'b0, 16'h0, 0);
    access(5'h00, 21'h000000, 1'b1, 1'b1, 16'hFFFF, 1);

    finish_run();
  end
endmodule